// File: doc/BRIEF.md
# Dual Bus Transceiver Control Logic

This block is the digital control layer that sits between a pair of bi-phase (Manchester) bus encoders/decoders and the analog front end of a two-channel bus transceiver. Channel index 0 is bus A and index 1 is bus B. For each channel it turns a complementary pair of transmit data inputs and an inhibit input into a driver enable plus positive and negative drive signals. It also gates the complementary comparator outputs of the receiver front end with a receiver enable.

A single amplitude selector is shared by both channels. It decodes a two-bit code that stands for a three-level select pin. The code chooses whether the transmit amplitude follows an external analog control voltage or an 8-bit DAC code. When the DAC is chosen, the code also picks one of two step sizes. The block reports the resulting nominal amplitude in millivolts and flags analog mode. Every output is registered on the system clock and appears one cycle after its inputs.

Top module: `dual_xcvr_ctrl`

## Requirements
- R1: When a channel's two transmit inputs are equal (both 0 or both 1), the next cycle shows drv_en = 0 and drv_p = drv_n = 0 for that channel.
- R2: When a channel's tx_inh is 1, the next cycle shows drv_en = 0 and drv_p = drv_n = 0 for that channel, whatever its data inputs are.
- R3: When tx_inh is 0 and tx_p differs from tx_n, the next cycle shows drv_en = 1, drv_p = tx_p and drv_n = tx_n.
- R4: When rx_en is 0, both rx_p and rx_n of that channel read 0 on the next cycle; when rx_en is 1, they follow cmp_p and cmp_n one cycle later.
- R5: amp_sel = 2'b00 (select pin low) gives use_analog = 0 and amp_mv = 19 × dac_code on the next cycle (0 to 4845 mV).
- R6: amp_sel = 2'b01 (select pin floating) gives use_analog = 1 and amp_mv = 0 on the next cycle. The unused code 2'b11 is handled the same way.
- R7: amp_sel = 2'b10 (select pin high) gives use_analog = 0 and amp_mv = 101 × dac_code on the next cycle (0 to 25755 mV).
- R8: Channel A (bit 0) and channel B (bit 1) are independent: the inputs of one channel never affect the outputs of the other.
- R9: A synchronous active-low reset clears every output to 0. Outside reset, every output changes exactly one clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_p | input | 2 | Non-inverted Manchester transmit data, per channel |
| tx_n | input | 2 | Inverted Manchester transmit data, per channel |
| tx_inh | input | 2 | Transmit inhibit, 1 forces the driver off, per channel |
| rx_en | input | 2 | Receiver enable, 0 forces the receiver outputs low, per channel |
| cmp_p | input | 2 | Non-inverted comparator output from the receiver front end |
| cmp_n | input | 2 | Inverted comparator output from the receiver front end |
| amp_sel | input | 2 | Amplitude source code: 00 low, 01 float, 10 high, 11 treated as float |
| dac_code | input | 8 | DAC amplitude code |
| drv_en | output | 2 | Driver enable, 0 means high impedance, per channel |
| drv_p | output | 2 | Positive drive level, per channel |
| drv_n | output | 2 | Negative drive level, per channel |
| rx_p | output | 2 | Gated non-inverted receive data, per channel |
| rx_n | output | 2 | Gated inverted receive data, per channel |
| use_analog | output | 1 | 1 when the external analog control sets the amplitude |
| amp_mv | output | 15 | Nominal amplitude in millivolts, 0 in analog mode |

## Verification
The assertions assume that inputs are synchronous to clk and hold one stable value across each rising edge. They also assume that amp_sel carries only the four defined codes, with no X or Z, because the three-level pin is resolved outside this block. The bench meets these assumptions by changing every input only on the falling edge and by driving only defined two-bit codes. It sweeps all 64 combinations of the six per-channel inputs on both channels at once, with a different pattern on each channel.

// File: rtl/xcvr_pkg.sv
// Package: shared types and constants for the dual transceiver control logic.
// Assumes the three-level select pin is resolved to a two-bit code outside.
package xcvr_pkg;

    // Amplitude source code as seen after the three-level pin resolver
    typedef enum logic [1:0] {
        AMP_DAC_FINE   = 2'b00,  // pin low: DAC with fine step
        AMP_ANALOG     = 2'b01,  // pin floating: external analog control
        AMP_DAC_COARSE = 2'b10,  // pin high: DAC with coarse step
        AMP_RESERVED   = 2'b11   // not produced by the resolver, treated as analog
    } amp_sel_t;

endpackage

// File: rtl/xcvr_chan.sv
// Module: xcvr_chan
// One transceiver channel. The driver is enabled only when the inhibit input
// is clear and the complementary data inputs differ. While enabled, each drive
// level follows its data input. Receive data is gated by the receiver enable.
// All outputs are registered. Assumes inputs are synchronous to clk.
module xcvr_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_p,
    input  logic tx_n,
    input  logic tx_inh,
    input  logic rx_en,
    input  logic cmp_p,
    input  logic cmp_n,
    output logic drv_en,
    output logic drv_p,
    output logic drv_n,
    output logic rx_p,
    output logic rx_n
);

    logic drive_ok;

    // Driver qualification: the pair must differ and the inhibit must be clear
    always_comb begin
        drive_ok = !tx_inh && (tx_p != tx_n);
    end

    // Driver register: the drive levels are zeroed while high impedance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_en <= 1'b0;
            drv_p  <= 1'b0;
            drv_n  <= 1'b0;
        end else begin
            drv_en <= drive_ok;
            drv_p  <= drive_ok & tx_p;
            drv_n  <= drive_ok & tx_n;
        end
    end

    // Receiver register: gate both comparator outputs with the enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_p <= 1'b0;
            rx_n <= 1'b0;
        end else begin
            rx_p <= rx_en & cmp_p;
            rx_n <= rx_en & cmp_n;
        end
    end

    // R1: equal data inputs leave the driver off on the next cycle
    p_equal_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_p == tx_n) |=> (!drv_en && !drv_p && !drv_n));

    // R2: inhibit forces the driver off
    p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_inh |=> (!drv_en && !drv_p && !drv_n));

    // R3: an enabled driver always shows opposite drive levels
    p_polarity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (drv_p != drv_n));

    // R4: a disabled receiver reads low on both outputs
    p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!rx_p && !rx_n));

endmodule

// File: rtl/amp_scale.sv
// Module: amp_scale
// Shared amplitude source selector. It decodes the select code and registers
// the analog-mode flag and the nominal amplitude in millivolts (step × code).
// Assumes the step constants times the largest code fit in MV_W bits.
module amp_scale
    import xcvr_pkg::*;
#(
    parameter int DAC_W      = 8,
    parameter int MV_W       = 15,
    parameter int STEP_LO_MV = 19,
    parameter int STEP_HI_MV = 101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       amp_sel,
    input  logic [DAC_W-1:0] dac_code,
    output logic             use_analog,
    output logic [MV_W-1:0]  amp_mv
);

    localparam int          CODE_MAX = (1 << DAC_W) - 1;
    localparam int          MV_MAX   = STEP_HI_MV * CODE_MAX;
    localparam logic [MV_W-1:0] STEP_LO = MV_W'(STEP_LO_MV);
    localparam logic [MV_W-1:0] STEP_HI = MV_W'(STEP_HI_MV);

    amp_sel_t        sel;
    logic            analog_d;
    logic [MV_W-1:0] step_d;
    logic [MV_W-1:0] mv_d;

    // Select decode: choose the source and the step size
    always_comb begin
        sel = amp_sel_t'(amp_sel);
        unique case (sel)
            AMP_DAC_FINE:   begin analog_d = 1'b0; step_d = STEP_LO;  end
            AMP_DAC_COARSE: begin analog_d = 1'b0; step_d = STEP_HI;  end
            default:        begin analog_d = 1'b1; step_d = '0;       end
        endcase
        mv_d = MV_W'(step_d * MV_W'(dac_code));
    end

    // Output register for the mode flag and the amplitude
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_analog <= 1'b0;
            amp_mv     <= '0;
        end else begin
            use_analog <= analog_d;
            amp_mv     <= mv_d;
        end
    end

    // R5: a low select scales the DAC code by the fine step
    p_fine_scale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_sel == 2'b00) |=> (!use_analog &&
            (32'(amp_mv) == STEP_LO_MV * 32'($past(dac_code)))));

    // R6: a floating or reserved select reports analog mode with zero amplitude
    p_analog_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        amp_sel[0] |=> (use_analog && (amp_mv == '0)));

    // R7: a high select scales the DAC code by the coarse step
    p_coarse_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_sel == 2'b10) |=> (!use_analog &&
            (32'(amp_mv) == STEP_HI_MV * 32'($past(dac_code)))));

    // R7: the amplitude never exceeds the coarse full scale
    p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(amp_mv) <= MV_MAX);

endmodule

// File: rtl/dual_xcvr_ctrl.sv
// Module: dual_xcvr_ctrl
// Top level: one xcvr_chan per bus channel (bit 0 = A, bit 1 = B) and one
// shared amp_scale. It adds no logic of its own beyond the wiring.
module dual_xcvr_ctrl #(
    parameter int CH_N       = 2,
    parameter int DAC_W      = 8,
    parameter int MV_W       = 15,
    parameter int STEP_LO_MV = 19,
    parameter int STEP_HI_MV = 101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_N-1:0]  tx_p,
    input  logic [CH_N-1:0]  tx_n,
    input  logic [CH_N-1:0]  tx_inh,
    input  logic [CH_N-1:0]  rx_en,
    input  logic [CH_N-1:0]  cmp_p,
    input  logic [CH_N-1:0]  cmp_n,
    input  logic [1:0]       amp_sel,
    input  logic [DAC_W-1:0] dac_code,
    output logic [CH_N-1:0]  drv_en,
    output logic [CH_N-1:0]  drv_p,
    output logic [CH_N-1:0]  drv_n,
    output logic [CH_N-1:0]  rx_p,
    output logic [CH_N-1:0]  rx_n,
    output logic             use_analog,
    output logic [MV_W-1:0]  amp_mv
);

    // R8: channels are built as separate instances with no shared state
    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        xcvr_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tx_p   (tx_p[c]),
            .tx_n   (tx_n[c]),
            .tx_inh (tx_inh[c]),
            .rx_en  (rx_en[c]),
            .cmp_p  (cmp_p[c]),
            .cmp_n  (cmp_n[c]),
            .drv_en (drv_en[c]),
            .drv_p  (drv_p[c]),
            .drv_n  (drv_n[c]),
            .rx_p   (rx_p[c]),
            .rx_n   (rx_n[c])
        );
    end

    amp_scale #(
        .DAC_W      (DAC_W),
        .MV_W       (MV_W),
        .STEP_LO_MV (STEP_LO_MV),
        .STEP_HI_MV (STEP_HI_MV)
    ) u_amp (
        .clk        (clk),
        .rst_n      (rst_n),
        .amp_sel    (amp_sel),
        .dac_code   (dac_code),
        .use_analog (use_analog),
        .amp_mv     (amp_mv)
    );

    // R9: outputs stay cleared for the cycle after reset is held
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (drv_en == '0 && rx_p == '0 && rx_n == '0 && amp_mv == '0 && !use_analog));

endmodule

// File: tb/tb_dual_xcvr_ctrl.sv
module tb_dual_xcvr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tx_p = '0, tx_n = '0, tx_inh = '0, rx_en = '0, cmp_p = '0, cmp_n = '0;
    logic [1:0]  amp_sel = '0;
    logic [7:0]  dac_code = '0;
    logic [1:0]  drv_en, drv_p, drv_n, rx_p, rx_n;
    logic        use_analog;
    logic [14:0] amp_mv;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dual_xcvr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tx_p(tx_p), .tx_n(tx_n), .tx_inh(tx_inh),
        .rx_en(rx_en), .cmp_p(cmp_p), .cmp_n(cmp_n), .amp_sel(amp_sel),
        .dac_code(dac_code), .drv_en(drv_en), .drv_p(drv_p), .drv_n(drv_n),
        .rx_p(rx_p), .rx_n(rx_n), .use_analog(use_analog), .amp_mv(amp_mv)
    );

    // Amplitude vectors: {sel[1:0], code[7:0], expected mV[14:0], expected analog}
    localparam int NAMP = 12;
    localparam logic [25:0] AMP_VEC [NAMP] = '{
        {2'b00, 8'd0,   15'd0,     1'b0},
        {2'b00, 8'd1,   15'd19,    1'b0},
        {2'b00, 8'd99,  15'd1881,  1'b0},
        {2'b00, 8'd128, 15'd2432,  1'b0},
        {2'b00, 8'd255, 15'd4845,  1'b0},
        {2'b10, 8'd0,   15'd0,     1'b0},
        {2'b10, 8'd1,   15'd101,   1'b0},
        {2'b10, 8'd37,  15'd3737,  1'b0},
        {2'b10, 8'd128, 15'd12928, 1'b0},
        {2'b10, 8'd255, 15'd25755, 1'b0},
        {2'b01, 8'd200, 15'd0,     1'b1},
        {2'b11, 8'd77,  15'd0,     1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected driver bits {en,p,n} for v = {txp,txn,inh,rxen,cp,cn}
    function automatic logic [2:0] exp_drv(input logic [5:0] v);
        logic en;
        en = !v[3] && (v[5] != v[4]);
        return {en, en & v[5], en & v[4]};
    endfunction

    function automatic logic [1:0] exp_rx(input logic [5:0] v);
        return {v[2] & v[1], v[2] & v[0]};
    endfunction

    function automatic string drv_tag(input logic [5:0] v);
        if (v[3]) return "R2";
        if (v[5] == v[4]) return "R1";
        return "R3";
    endfunction

    task automatic drive_ch(input int c, input logic [5:0] v);
        tx_p[c] = v[5]; tx_n[c] = v[4]; tx_inh[c] = v[3];
        rx_en[c] = v[2]; cmp_p[c] = v[1]; cmp_n[c] = v[0];
    endtask

    task automatic check_ch(input int c, input logic [5:0] v);
        chk({drv_tag(v), " drv ch", (c == 0) ? "A" : "B"},
            int'({drv_en[c], drv_p[c], drv_n[c]}), int'(exp_drv(v)));
        chk({"R4 rx ch", (c == 0) ? "A" : "B"},
            int'({rx_p[c], rx_n[c]}), int'(exp_rx(v)));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        // R9: reset clears outputs even with active inputs
        tx_p = 2'b11; tx_n = 2'b00; rx_en = 2'b11; cmp_p = 2'b11; cmp_n = 2'b11;
        amp_sel = 2'b10; dac_code = 8'd255;
        repeat (3) @(negedge clk);
        chk("R9 reset drv_en", int'(drv_en), 0);
        chk("R9 reset rx", int'({rx_p, rx_n}), 0);
        chk("R9 reset amp_mv", int'(amp_mv), 0);
        chk("R9 reset use_analog", int'(use_analog), 0);
        rst_n = 1'b1;
        tx_p = '0; tx_n = '0; rx_en = '0; cmp_p = '0; cmp_n = '0; amp_sel = '0; dac_code = '0;
        @(negedge clk);

        // R1 R2 R3 R4 R8: every input combination, different pattern per channel
        for (int i = 0; i < 64; i++) begin
            logic [5:0] va, vb;
            va = 6'(i);
            vb = 6'(63 - i) ^ 6'(i << 2);
            drive_ch(0, va);
            drive_ch(1, vb);
            @(negedge clk);
            check_ch(0, va);
            check_ch(1, vb);
        end

        // R5 R6 R7: amplitude table
        for (int k = 0; k < NAMP; k++) begin
            amp_sel  = AMP_VEC[k][25:24];
            dac_code = AMP_VEC[k][23:16];
            @(negedge clk);
            chk((AMP_VEC[k][25:24] == 2'b00) ? "R5 amp_mv" :
                (AMP_VEC[k][25:24] == 2'b10) ? "R7 amp_mv" : "R6 amp_mv",
                int'(amp_mv), int'(AMP_VEC[k][15:1]));
            chk("R6 use_analog", int'(use_analog), int'(AMP_VEC[k][0]));
        end

        // R9: one-cycle latency, output holds until the next edge
        drive_ch(0, 6'b100000); drive_ch(1, 6'b000000);
        amp_sel = 2'b10; dac_code = 8'd10;
        @(negedge clk);
        chk("R9 setup drv_en", int'(drv_en), 1);
        drive_ch(0, 6'b001000);
        amp_sel = 2'b00; dac_code = 8'd2;
        #2;
        chk("R9 latency drv_en held", int'(drv_en), 1);
        chk("R9 latency amp held", int'(amp_mv), 1010);
        @(negedge clk);
        chk("R2 inhibit after edge", int'(drv_en), 0);
        chk("R5 amp after edge", int'(amp_mv), 38);

        // R8: toggling channel B alone leaves channel A outputs unchanged
        drive_ch(0, 6'b010110);
        @(negedge clk);
        drive_ch(1, 6'b101111);
        @(negedge clk);
        chk("R8 chan A drive", int'({drv_en[0], drv_p[0], drv_n[0]}), 3'b101);
        chk("R8 chan A rx", int'({rx_p[0], rx_n[0]}), 2'b10);
        chk("R8 chan B rx", int'({rx_p[1], rx_n[1]}), 2'b11);

        // R9: reset in mid-run clears outputs again
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid reset", int'({drv_en, rx_p, rx_n, use_analog, amp_mv}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule